// File: doc/BRIEF.md
# Multi-Domain Link Reset Sequencer

This block produces the four active-low resets that a high-speed serial link core needs: one for the register-interface logic, one for the PHY, one for the link layer and one for the frame layer. Each reset lives in its own clock domain. Each one goes low as soon as its cause appears and comes back high only on an edge of its own clock, after a short synchronizer chain.

A system reset request clears everything. When the request lifts, the register and PHY resets release first. The link and frame resets then stay held for a configuration window of any length, so that run-time registers can be written. They release only once the register side reports configuration done, the PLL reports lock, the transceiver reports ready and software has no hold on the link. If any of those conditions drops later, the link and frame logic is thrown back into reset at once. The next release goes through the same gating.

A status bit in the register clock domain reports whether the link reset is currently released. All pins are plain level controls; the block has no data stream.

Top module: `link_reset_seq`

## Requirements
- R1: While sys_rst_n is low, reg_rst_n, phy_rst_n, link_rst_n, frame_rst_n and link_up are all 0. A fall of sys_rst_n at any time clears the four resets in the same time step, with no clock edge needed.
- R2: After sys_rst_n rises, reg_rst_n goes high on the second rising edge of reg_clk and phy_rst_n goes high on the second rising edge of phy_clk.
- R3: link_rst_n and frame_rst_n are never high while reg_rst_n or phy_rst_n is low, whatever the state of the other release conditions.
- R4: link_rst_n and frame_rst_n rise only while all of the following hold: cfg_done=1, pll_locked=1, xcvr_ready=1, sw_link_hold=0, reg_rst_n=1 and phy_rst_n=1. When the last of these becomes true, link_rst_n rises on the second following rising edge of link_clk and frame_rst_n rises on the second following rising edge of frame_clk.
- R5: When pll_locked, xcvr_ready or cfg_done goes low, link_rst_n and frame_rst_n fall in the same time step, with no clock edge needed.
- R6: After the link and frame resets have been re-asserted by any cause, including a fresh sys_rst_n pulse, they release again only under the full R4 gating.
- R7: sw_link_hold=1 holds link_rst_n and frame_rst_n low, even when every other release condition is met.
- R8: link_up, in the reg_clk domain, goes to 1 two reg_clk rising edges after link_rst_n is high at an edge. It returns to 0 two edges after link_rst_n is low at an edge, and it is 0 whenever reg_rst_n is low.
- R9: Every rise of link_rst_n happens at a rising edge of link_clk, and every rise of frame_rst_n happens at a rising edge of frame_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-interface clock |
| phy_clk | input | 1 | PHY clock |
| link_clk | input | 1 | Link-layer clock |
| frame_clk | input | 1 | Frame-layer clock |
| sys_rst_n | input | 1 | System reset request, active low, asynchronous |
| pll_locked | input | 1 | PLL lock flag, 1 = locked |
| xcvr_ready | input | 1 | Transceiver ready flag, 1 = ready |
| cfg_done | input | 1 | Register side has finished configuration, 1 = done |
| sw_link_hold | input | 1 | Software hold: 1 forces the link and frame resets low |
| reg_rst_n | output | 1 | Register-domain reset, active low |
| phy_rst_n | output | 1 | PHY-domain reset, active low |
| link_rst_n | output | 1 | Link-domain reset, active low |
| frame_rst_n | output | 1 | Frame-domain reset, active low |
| link_up | output | 1 | Register-domain status: link reset currently released |

## Verification
The bench runs the four clocks at unrelated periods. It changes conditions at times that do not fall on any clock edge, and it timestamps every release of the link and frame resets. This catches a design that releases on the wrong clock, or that counts one synchronizer stage too few or too many.

A release condition that is true during system reset exposes a sequencer that lets the link out before the register and PHY resets are gone. Dropping the PLL lock or the transceiver ready between edges exposes a design that only reacts on the next clock edge. A software hold, and a re-entry after a fresh reset with configuration not yet done, expose a design that remembers an earlier release instead of gating every release again.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  // Synchronizer depth used by every reset and status chain.
  localparam int unsigned LRS_SYNC_DEPTH = 2;

  // Release conditions gathered from the register side and the PHY.
  typedef struct packed {
    logic cfg_done;
    logic pll_locked;
    logic xcvr_ready;
    logic sw_hold;
  } lrs_cond_t;
endpackage

// File: rtl/lrs_rst_sync.sv
module lrs_rst_sync #(
  parameter int unsigned STAGES = lrs_pkg::LRS_SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n = chain_q[LAST];

  // R9
  sync_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> $past(arst_n));
endmodule

// File: rtl/lrs_bit_sync.sv
module lrs_bit_sync #(
  parameter int unsigned STAGES = lrs_pkg::LRS_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain_q[LAST];
endmodule

// File: rtl/lrs_gate.sv
module lrs_gate
  import lrs_pkg::*;
(
  input  logic      reg_ok,
  input  logic      phy_ok,
  input  lrs_cond_t cond,
  output logic      release_n
);
  // Level gate: any missing condition pulls the request low at once.
  always_comb begin
    release_n = reg_ok & phy_ok & cond.cfg_done & cond.pll_locked &
                cond.xcvr_ready & ~cond.sw_hold;
  end
endmodule

// File: rtl/link_reset_seq.sv
module link_reset_seq
  import lrs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = LRS_SYNC_DEPTH
) (
  input  logic reg_clk,
  input  logic phy_clk,
  input  logic link_clk,
  input  logic frame_clk,
  input  logic sys_rst_n,
  input  logic pll_locked,
  input  logic xcvr_ready,
  input  logic cfg_done,
  input  logic sw_link_hold,
  output logic reg_rst_n,
  output logic phy_rst_n,
  output logic link_rst_n,
  output logic frame_rst_n,
  output logic link_up
);
  lrs_cond_t cond;
  logic      lf_req_n;

  assign cond = '{cfg_done:   cfg_done,
                  pll_locked: pll_locked,
                  xcvr_ready: xcvr_ready,
                  sw_hold:    sw_link_hold};

  lrs_rst_sync #(.STAGES(SYNC_STAGES)) u_reg_sync (
    .clk(reg_clk), .arst_n(sys_rst_n), .rst_n(reg_rst_n));

  lrs_rst_sync #(.STAGES(SYNC_STAGES)) u_phy_sync (
    .clk(phy_clk), .arst_n(sys_rst_n), .rst_n(phy_rst_n));

  lrs_gate u_gate (
    .reg_ok(reg_rst_n), .phy_ok(phy_rst_n), .cond(cond), .release_n(lf_req_n));

  lrs_rst_sync #(.STAGES(SYNC_STAGES)) u_link_sync (
    .clk(link_clk), .arst_n(lf_req_n), .rst_n(link_rst_n));

  lrs_rst_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
    .clk(frame_clk), .arst_n(lf_req_n), .rst_n(frame_rst_n));

  lrs_bit_sync #(.STAGES(SYNC_STAGES)) u_status_sync (
    .clk(reg_clk), .rst_n(reg_rst_n), .d(link_rst_n), .q(link_up));

  // R3
  link_order_chk: assert property (@(posedge link_clk) disable iff (!sys_rst_n)
    link_rst_n |-> (reg_rst_n && phy_rst_n));

  // R3
  frame_order_chk: assert property (@(posedge frame_clk) disable iff (!sys_rst_n)
    frame_rst_n |-> (reg_rst_n && phy_rst_n));

  // R4
  link_gate_chk: assert property (@(posedge link_clk) disable iff (!sys_rst_n)
    $rose(link_rst_n) |-> (cfg_done && pll_locked && xcvr_ready && !sw_link_hold));

  // R4
  frame_gate_chk: assert property (@(posedge frame_clk) disable iff (!sys_rst_n)
    $rose(frame_rst_n) |-> (cfg_done && pll_locked && xcvr_ready && !sw_link_hold));

  // R5
  link_drop_chk: assert property (@(posedge link_clk) disable iff (!sys_rst_n)
    !(pll_locked && xcvr_ready) |-> !link_rst_n);

  // R7
  hold_chk: assert property (@(posedge frame_clk) disable iff (!sys_rst_n)
    sw_link_hold |-> !frame_rst_n);

  // R8
  status_chk: assert property (@(posedge reg_clk) disable iff (!sys_rst_n)
    $rose(link_up) |-> $past(link_rst_n));
endmodule

// File: tb/link_reset_seq_tb_top.sv
`timescale 1ns/1ps
module link_reset_seq_tb_top;
  logic reg_clk = 0, phy_clk = 0, link_clk = 0, frame_clk = 0;
  logic sys_rst_n = 0, pll_locked = 1, xcvr_ready = 1, cfg_done = 1, sw_link_hold = 0;
  logic reg_rst_n, phy_rst_n, link_rst_n, frame_rst_n, link_up;

  int n_chk = 0, n_fail = 0;
  int rc = 0, pc = 0, lc = 0, fc = 0;
  real t_link = -1.0, t_frame = -1.0;
  logic cond_all;

  always #2.0 reg_clk   = ~reg_clk;
  always #3.2 phy_clk   = ~phy_clk;
  always #2.7 link_clk  = ~link_clk;
  always #3.5 frame_clk = ~frame_clk;

  link_reset_seq dut_i (
    .reg_clk(reg_clk), .phy_clk(phy_clk), .link_clk(link_clk), .frame_clk(frame_clk),
    .sys_rst_n(sys_rst_n), .pll_locked(pll_locked), .xcvr_ready(xcvr_ready),
    .cfg_done(cfg_done), .sw_link_hold(sw_link_hold),
    .reg_rst_n(reg_rst_n), .phy_rst_n(phy_rst_n), .link_rst_n(link_rst_n),
    .frame_rst_n(frame_rst_n), .link_up(link_up));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // bench-side view of the release conditions (R4)
  assign cond_all = sys_rst_n & reg_rst_n & phy_rst_n & cfg_done & pll_locked &
                    xcvr_ready & ~sw_link_hold;

  always @(posedge reg_clk or negedge sys_rst_n)
    if (!sys_rst_n) rc = 0; else rc++;
  always @(posedge phy_clk or negedge sys_rst_n)
    if (!sys_rst_n) pc = 0; else pc++;
  always @(posedge link_clk or negedge cond_all)
    if (!cond_all) lc = 0; else begin lc++; t_link = $realtime; end
  always @(posedge frame_clk or negedge cond_all)
    if (!cond_all) fc = 0; else begin fc++; t_frame = $realtime; end
  always @(posedge link_clk)  t_link  = $realtime;
  always @(posedge frame_clk) t_frame = $realtime;

  // R2: exact release edge for register and PHY resets
  always @(posedge reg_rst_n) chk(rc == 2, "R2 reg release edge", rc, 2);
  always @(posedge phy_rst_n) chk(pc == 2, "R2 phy release edge", pc, 2);

  // R3 R4 R9: every link/frame release is gated and clock-aligned
  always @(posedge link_rst_n) begin
    chk(cond_all === 1'b1, "R4 link release gating", int'(cond_all), 1);
    chk(reg_rst_n && phy_rst_n, "R3 link after reg/phy", int'(reg_rst_n & phy_rst_n), 1);
    chk(lc >= 2, "R4 link sync depth", lc, 2);
    chk($realtime == t_link, "R9 link edge alignment", 0, 1);
  end
  always @(posedge frame_rst_n) begin
    chk(cond_all === 1'b1, "R4 frame release gating", int'(cond_all), 1);
    chk(reg_rst_n && phy_rst_n, "R3 frame after reg/phy", int'(reg_rst_n & phy_rst_n), 1);
    chk(fc >= 2, "R4 frame sync depth", fc, 2);
    chk($realtime == t_frame, "R9 frame edge alignment", 0, 1);
  end

  // {cfg_done, pll_locked, xcvr_ready, sw_link_hold, expected release}
  localparam logic [4:0] VECS [8] = '{
    5'b01100, 5'b11101, 5'b11110, 5'b11101,
    5'b10100, 5'b11000, 5'b01100, 5'b11101};

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400us;
    chk(1'b0, "WATCHDOG", 0, 1);
    finish_run();
  end

  initial begin
    // R1 R3: reset held, conditions already true
    #50.13;
    chk({reg_rst_n, phy_rst_n, link_rst_n, frame_rst_n, link_up} == 5'b0,
        "R1 reset state", int'({reg_rst_n, phy_rst_n, link_rst_n, frame_rst_n, link_up}), 0);
    @(negedge reg_clk); #0.13;
    sys_rst_n = 1;
    @(posedge reg_clk); #0.5;
    chk(reg_rst_n == 0, "R2 reg still low after one edge", int'(reg_rst_n), 0);
    @(posedge reg_clk); #0.5;
    chk(reg_rst_n == 1, "R2 reg high after two edges", int'(reg_rst_n), 1);
    #100.13;
    chk(link_rst_n && frame_rst_n, "R4 first release", int'(link_rst_n & frame_rst_n), 1);
    chk(link_up == 1, "R8 status after release", int'(link_up), 1);

    // vector table walk: R4 R5 R7 R8
    foreach (VECS[i]) begin
      @(negedge link_clk); #0.13;
      {cfg_done, pll_locked, xcvr_ready, sw_link_hold} = VECS[i][4:1];
      repeat (30) @(negedge link_clk);
      chk(link_rst_n == VECS[i][0], "R4/R5/R7 link vector", int'(link_rst_n), int'(VECS[i][0]));
      chk(frame_rst_n == VECS[i][0], "R4/R5/R7 frame vector", int'(frame_rst_n), int'(VECS[i][0]));
      chk(link_up == VECS[i][0], "R8 status vector", int'(link_up), int'(VECS[i][0]));
    end

    // R4 R9: exact link latency
    pll_locked = 0;
    repeat (5) @(negedge link_clk);
    pll_locked = 1;
    @(negedge link_clk);
    chk(link_rst_n == 0, "R4 link low after one edge", int'(link_rst_n), 0);
    @(negedge link_clk);
    chk(link_rst_n == 1, "R4 link high after two edges", int'(link_rst_n), 1);

    // R4 R9: exact frame latency
    pll_locked = 0;
    repeat (5) @(negedge frame_clk);
    pll_locked = 1;
    @(negedge frame_clk);
    chk(frame_rst_n == 0, "R4 frame low after one edge", int'(frame_rst_n), 0);
    @(negedge frame_clk);
    chk(frame_rst_n == 1, "R4 frame high after two edges", int'(frame_rst_n), 1);

    // R5: drop between edges acts without a clock
    repeat (10) @(negedge reg_clk);
    #0.73 xcvr_ready = 0;
    #0.1;
    chk(!link_rst_n && !frame_rst_n, "R5 immediate drop on ready", int'(link_rst_n | frame_rst_n), 0);
    xcvr_ready = 1;
    #100.13;
    #0.61 cfg_done = 0;
    #0.1;
    chk(!link_rst_n && !frame_rst_n, "R5 immediate drop on cfg", int'(link_rst_n | frame_rst_n), 0);
    cfg_done = 1;
    #100.13;
    chk(link_rst_n == 1, "R6 release after cfg return", int'(link_rst_n), 1);

    // R1 R6: fresh system reset mid-run, config phase not yet done
    #0.29 sys_rst_n = 0;
    #0.1;
    chk({reg_rst_n, phy_rst_n, link_rst_n, frame_rst_n} == 4'b0,
        "R1 async assert mid-run", int'({reg_rst_n, phy_rst_n, link_rst_n, frame_rst_n}), 0);
    #1.0;
    chk(link_up == 0, "R8 status cleared by reg reset", int'(link_up), 0);
    cfg_done = 0;
    #20.0;
    @(negedge reg_clk); #0.13;
    sys_rst_n = 1;
    #200.13;
    chk(reg_rst_n && phy_rst_n, "R2 reg/phy re-release", int'(reg_rst_n & phy_rst_n), 1);
    chk(!link_rst_n && !frame_rst_n, "R6 held in config phase", int'(link_rst_n | frame_rst_n), 0);
    chk(link_up == 0, "R8 status low while held", int'(link_up), 0);
    cfg_done = 1;
    #100.13;
    chk(link_rst_n && frame_rst_n, "R6 re-release after config", int'(link_rst_n & frame_rst_n), 1);
    chk(link_up == 1, "R8 status after re-release", int'(link_up), 1);

    finish_run();
  end
endmodule